// File: doc/BRIEF.md
# Nine-code scan-chain decompressor

This block sits between a tester's serial pin and a single scan chain. The tester sends a compressed stream, one bit per clock. Each block of K scan bits is coded as a short prefix-free codeword, followed by the literal bits of any half that is neither all zeros nor all ones. The decoder has nine codewords, and the code does not depend on K. The block recognises the codeword and expands each K/2-bit half into the chain. A half is either a run of a constant or the literal bits it received, which it holds in a K/2-bit shifter. While the block shifts bits into the chain it raises a scan enable. After the second half it sends a one-cycle acknowledge, which tells the tester that the next codeword may follow.

Input bits are taken only on cycles where the decode enable is high, so the tester may pause at any time while a codeword or a run of literal bits is being sent. The whole block runs from one clock. Reset is synchronous and active high.

Top module: `ninecode_scan_decomp`

## Requirements
- R1: A synchronous reset, applied in any state, leaves scan_en, ack and scan_out low from the next cycle on. The first bit accepted afterwards is treated as the first bit of a new codeword.
- R2: Codeword and literal bits are consumed only on clock edges where dec_en is 1. Cycles where dec_en is 0 stall the block, and the data bit on those cycles has no effect.
- R3: Codewords are sent first bit first, and each selects a source for the (left, right) half. 0 gives (zero, zero). 10 gives (one, one). 11000 gives (zero, one). 11001 gives (one, zero). 11010 gives (one, literal). 11011 gives (literal, one). 11100 gives (zero, literal). 11101 gives (literal, zero). 1111 gives (literal, literal).
- R4: A constant half produces K/2 consecutive scan cycles, all carrying that constant.
- R5: A literal half consumes K/2 bits and then emits them in the order they arrived. For 1111, the left half's bits are received and emitted before the right half's bits are received.
- R6: scan_en is high in exactly the emission cycles. A half's emission starts in the cycle after its last consumed bit and lasts K/2 cycles. The left half is always emitted before the right half.
- R7: ack is high for exactly one cycle, the cycle after the last emitted bit of a block. scan_en is low during that cycle.
- R8: dec_en and data_in are ignored during emission cycles and during the ack cycle.
- R9: scan_out is 0 whenever scan_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the tester stream and the scan chain |
| rst | input | 1 | Synchronous reset, active high |
| dec_en | input | 1 | Qualifies data_in as a stream bit |
| data_in | input | 1 | Serial compressed stream |
| scan_out | output | 1 | Bit driven into the scan chain |
| scan_en | output | 1 | High while a decoded bit is shifted into the chain |
| ack | output | 1 | One-cycle request for the next codeword |

## Verification
The ack pulse and the tester's next codeword bit can arrive in the same cycle. A tester that runs ahead will raise dec_en with a 1 while ack is high. The bench provokes this at random on many blocks and often follows it with a block coded as the single bit 0. If the stray 1 were accepted, that block would decode as all ones instead of all zeros. Emission cycles can likewise meet a live dec_en with random data. These cases are judged by comparing the full K-bit output of each block, and the timing of its enable, against values the bench computes from the code table.

// File: rtl/ninecode_scan_decomp.sv
module ninecode_scan_decomp #(
  parameter int K = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic dec_en,
  input  logic data_in,
  output logic scan_out,
  output logic scan_en,
  output logic ack
);
  localparam int HALF = K / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int RW   = $clog2(K + 2);

  localparam logic [1:0] SRC_ZERO = 2'd0;
  localparam logic [1:0] SRC_ONE  = 2'd1;
  localparam logic [1:0] SRC_LIT  = 2'd2;

  typedef enum logic [1:0] {ST_CODE, ST_LOAD, ST_EMIT, ST_ACK} state_t;

  state_t          st;
  logic [2:0]      nbits;
  logic [2:0]      hist;
  logic            half;
  logic [CW-1:0]   cnt;
  logic [1:0]      src_l, src_r;
  logic [HALF-1:0] sh;

  logic            found;
  logic [1:0]      f_l, f_r;

  wire [1:0] cur_src = half ? src_r : src_l;
  wire       last    = (cnt == CW'(HALF - 1));

  always_comb begin
    found = 1'b0;
    f_l   = SRC_ZERO;
    f_r   = SRC_ZERO;
    if (st == ST_CODE && dec_en) begin
      case (nbits)
        3'd0: found = !data_in;
        3'd1: if (!data_in) begin
          found = 1'b1;
          f_l   = SRC_ONE;
          f_r   = SRC_ONE;
        end
        3'd3: if (hist[0] && data_in) begin
          found = 1'b1;
          f_l   = SRC_LIT;
          f_r   = SRC_LIT;
        end
        3'd4: begin
          found = 1'b1;
          case ({hist[1], hist[0], data_in})
            3'b000:  begin f_l = SRC_ZERO; f_r = SRC_ONE;  end
            3'b001:  begin f_l = SRC_ONE;  f_r = SRC_ZERO; end
            3'b010:  begin f_l = SRC_ONE;  f_r = SRC_LIT;  end
            3'b011:  begin f_l = SRC_LIT;  f_r = SRC_ONE;  end
            3'b100:  begin f_l = SRC_ZERO; f_r = SRC_LIT;  end
            3'b101:  begin f_l = SRC_LIT;  f_r = SRC_ZERO; end
            default: begin f_l = SRC_ZERO; f_r = SRC_ZERO; end
          endcase
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_CODE;
      nbits <= 3'd0;
      hist  <= 3'd0;
      half  <= 1'b0;
      cnt   <= '0;
      src_l <= SRC_ZERO;
      src_r <= SRC_ZERO;
      sh    <= '0;
    end else begin
      case (st)
        ST_CODE: if (dec_en) begin
          if (found) begin
            src_l <= f_l;
            src_r <= f_r;
            nbits <= 3'd0;
            half  <= 1'b0;
            cnt   <= '0;
            st    <= (f_l == SRC_LIT) ? ST_LOAD : ST_EMIT;
          end else begin
            nbits <= nbits + 3'd1;
            hist  <= {hist[1:0], data_in};
          end
        end
        ST_LOAD: if (dec_en) begin
          sh <= {sh[HALF-2:0], data_in};
          if (last) begin
            cnt <= '0;
            st  <= ST_EMIT;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_EMIT: begin
          if (cur_src == SRC_LIT) sh <= sh << 1;
          if (last) begin
            cnt <= '0;
            if (half) begin
              st <= ST_ACK;
            end else begin
              half <= 1'b1;
              st   <= (src_r == SRC_LIT) ? ST_LOAD : ST_EMIT;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          half <= 1'b0;
          st   <= ST_CODE;
        end
      endcase
    end
  end

  assign scan_en  = (st == ST_EMIT);
  assign ack      = (st == ST_ACK);
  assign scan_out = scan_en & ((cur_src == SRC_ONE) | ((cur_src == SRC_LIT) & sh[HALF-1]));

  logic [RW-1:0] run;
  always_ff @(posedge clk) begin
    if (rst)          run <= '0;
    else if (scan_en) run <= run + 1'b1;
    else              run <= '0;
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!scan_en && !ack && !scan_out));

  assert_run_len_R6: assert property (@(posedge clk) disable iff (rst)
    run <= RW'(K));

  assert_ack_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);

  assert_ack_after_emit_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(ack) |-> $past(scan_en));

  assert_ack_no_scan_R7: assert property (@(posedge clk) disable iff (rst)
    ack |-> !scan_en);

  assert_quiet_out_R9: assert property (@(posedge clk) disable iff (rst)
    !scan_en |-> !scan_out);
endmodule

// File: tb/ninecode_scan_decomp_tb.sv
`timescale 1ns/1ps
module ninecode_scan_decomp_tb;
  localparam int K    = 8;
  localparam int HALF = K / 2;

  logic clk = 1'b0;
  logic rst, dec_en, data_in;
  logic scan_out, scan_en, ack;
  int   total = 0, failed = 0;
  bit   done = 0;

  always #10 clk = ~clk;

  ninecode_scan_decomp #(.K(K)) u_dut (
    .clk(clk), .rst(rst), .dec_en(dec_en), .data_in(data_in),
    .scan_out(scan_out), .scan_en(scan_en), .ack(ack)
  );

  function automatic logic [7:0] codeword(int c);
    case (c)
      1: return {3'd1, 5'b00000};
      2: return {3'd2, 5'b00010};
      3: return {3'd5, 5'b11000};
      4: return {3'd5, 5'b11001};
      5: return {3'd5, 5'b11010};
      6: return {3'd5, 5'b11011};
      7: return {3'd5, 5'b11100};
      8: return {3'd5, 5'b11101};
      default: return {3'd4, 5'b01111};
    endcase
  endfunction

  function automatic int src_of(int c, bit right);
    case (c)
      1: return 0;
      2: return 1;
      3: return right ? 1 : 0;
      4: return right ? 0 : 1;
      5: return right ? 2 : 1;
      6: return right ? 1 : 2;
      7: return right ? 2 : 0;
      8: return right ? 0 : 2;
      default: return 2;
    endcase
  endfunction

  function automatic logic [HALF-1:0] half_val(int s, logic [HALF-1:0] lit);
    if (s == 0) return '0;
    if (s == 1) return '1;
    return lit;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(bit en, bit d);
    dec_en  = en;
    data_in = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  int bad_idle;

  task automatic idle_chk();
    if (scan_en !== 1'b0 || ack !== 1'b0 || scan_out !== 1'b0) bad_idle++;
  endtask

  task automatic feed(bit b, int pct);
    while (int'($urandom_range(99)) < pct) begin
      idle_chk();
      drive(1'b0, 1'($urandom));
    end
    idle_chk();
    drive(1'b1, b);
  endtask

  task automatic run_block(int c, logic [HALF-1:0] lit_l, logic [HALF-1:0] lit_r,
                           int pct, bit poke);
    logic [7:0]   cw;
    logic [K-1:0] got, expv;
    int           bad_en, n;
    bit           ack_ok;
    cw = codeword(c);
    n  = int'(cw[7:5]);
    bad_en = 0;
    bad_idle = 0;
    got = '0;
    for (int i = n - 1; i >= 0; i--) feed(cw[i], pct);
    for (int h = 0; h < 2; h++) begin
      if (src_of(c, h[0]) == 2)
        for (int i = HALF - 1; i >= 0; i--) feed(h == 0 ? lit_l[i] : lit_r[i], pct);
      for (int i = 0; i < HALF; i++) begin
        if (scan_en !== 1'b1) bad_en++;
        got = {got[K-2:0], scan_out};
        drive(1'($urandom), 1'($urandom));
      end
    end
    ack_ok = (ack === 1'b1) && (scan_en === 1'b0);
    drive(poke, 1'b1);
    expv = {half_val(src_of(c, 1'b0), lit_l), half_val(src_of(c, 1'b1), lit_r)};
    chk(got === expv, $sformatf("R3/R4/R5 block code %0d", c), got, expv);
    chk(bad_en == 0 && bad_idle == 0, $sformatf("R6/R9/R2 enable timing code %0d", c),
        bad_en + bad_idle, 0);
    chk(ack_ok, $sformatf("R7/R8 ack cycle code %0d", c), ack_ok, 1);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      total++;
      failed++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h9C0DE));
    rst = 1'b1; dec_en = 1'b0; data_in = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(scan_en === 1'b0 && ack === 1'b0 && scan_out === 1'b0, "R1 reset state",
        {scan_en, ack, scan_out}, 0);

    for (int c = 1; c <= 9; c++) run_block(c, 4'b1011, 4'b0110, 0, 1'b0);
    for (int c = 1; c <= 9; c++) run_block(c, 4'b0001, 4'b1000, 50, 1'b1);
    run_block(9, 4'b0000, 4'b1111, 0, 1'b1);
    run_block(1, 4'b0000, 4'b0000, 0, 1'b1);

    // R1: reset during emission of an all-ones block
    feed(1'b1, 0);
    feed(1'b0, 0);
    chk(scan_en === 1'b1 && scan_out === 1'b1, "R6 emission starts after code", {scan_en, scan_out}, 3);
    drive(1'b0, 1'b0);
    rst = 1'b1;
    drive(1'b0, 1'b0);
    rst = 1'b0;
    chk(scan_en === 1'b0 && ack === 1'b0 && scan_out === 1'b0, "R1 reset mid emission",
        {scan_en, ack, scan_out}, 0);
    run_block(1, 4'b0000, 4'b0000, 0, 1'b0);

    // R1: reset while a codeword is half received
    feed(1'b1, 0);
    feed(1'b1, 0);
    rst = 1'b1;
    drive(1'b1, 1'b1);
    rst = 1'b0;
    run_block(1, 4'b0000, 4'b0000, 0, 1'b0);

    for (int t = 0; t < 300; t++) begin
      int c = int'($urandom_range(1, 9));
      run_block(c, HALF'($urandom), HALF'($urandom), int'($urandom_range(0, 3)) * 20,
                1'($urandom));
      if ((t % 7) == 0) run_block(1, 4'b0000, 4'b0000, 0, 1'b0);
    end

    done = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule